// File: doc/BRIEF.md
# Serial CRC-8 Generator and Checker

This block computes an 8-bit cyclic check value one bit at a time. Its main use is with a 64-bit device identity. That identity is an 8-bit family code, then a 48-bit serial number, then the 8-bit check value itself. To generate the check value, the user clears the unit and feeds the first 56 identity bits, least significant bit first. The accumulator then holds the check value.

To verify a received identity, the user feeds all 64 bits. The accumulator must return to zero. A separate flag reports that the zero residue came after exactly 64 bits since the last clear.

Each accepted bit is combined with the accumulator bit 0. The accumulator shifts toward bit 0, and the feedback enters at bit 7 and at the taps for x^4 and x^5. This is the reflected form of x^8 + x^5 + x^4 + 1, with constant 0x8C.

Top module: `crc8_serial_unit`

## Requirements
- R1: After reset, `crc_o` is 0x00, `zero_o` is 1 and `id_ok_o` is 0.
- R2: On a clock edge with `bit_vld_i` high and `clr_i` low, the new CRC is `(crc >> 1) ^ (fb ? 8'h8C : 8'h00)`, where `fb = crc[0] ^ bit_i`.
- R3: On a clock edge with `bit_vld_i` and `clr_i` both low, `crc_o` and the bit count keep their values.
- R4: A clock edge with `clr_i` high sets the CRC to 0x00 and the bit count to 0. This holds even when `bit_vld_i` is high in the same cycle, and that bit is dropped.
- R5: After a clear, feeding 56 identity bits (family code LSB first, then serial bytes LSB first) leaves the check value in `crc_o`. For example, the bytes 02 1C B8 01 00 00 00 give 0xA2.
- R6: Feeding the 56 identity bits and then the 8 bits of their check value, LSB first, leaves `crc_o` at 0x00 and raises `id_ok_o`.
- R7: `id_ok_o` is 1 only when the CRC is zero and exactly 64 bits have been accepted since the last clear or reset. With 63 bits it is 0. With 65 or more bits it is 0, because the count saturates above 64.
- R8: `zero_o` is 1 exactly when `crc_o` is 0x00, whatever the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clears CRC and bit count; takes priority over a data bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial data bit, LSB first |
| crc_o | output | 8 | Current CRC accumulator |
| zero_o | output | 1 | Accumulator is zero |
| id_ok_o | output | 1 | Zero residue after exactly 64 bits |

## Verification
The hard case is a zero residue reached with the wrong bit count. An all-zero stream keeps the accumulator at zero, so zero data bits can be added or removed without changing the CRC. The bench uses this to test 63 bits, exactly 64 bits, and a 65th zero bit after a good identity. In each case `zero_o` stays high while `id_ok_o` must follow the count alone. A sweep over all 256 single-byte inputs, a known identity, and LFSR-generated identities then exercise the feedback taps against the bench's own tap-by-tap model.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

  // One reflected CRC step: the feedback enters at the top and at the tap positions
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic din);
    logic fb;
    fb = cur[0] ^ din;
    return (cur >> 1) ^ (fb ? POLY_REFL : '0);
  endfunction
endpackage

// File: rtl/crc8_shift_reg.sv
module crc8_shift_reg
  import crc8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;

  assign crc_next = crc_step(crc_q, din_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) crc_q <= '0;
    else if (step_i)     crc_q <= crc_next;
  end

  assign crc_o = crc_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(crc_q));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_q == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> (crc_q == crc_step($past(crc_q), $past(din_i))));
endmodule

// File: rtl/crc8_bit_counter.sv
module crc8_bit_counter #(
  parameter int ID_BITS = 64,
  localparam int CNT_W  = $clog2(ID_BITS + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic at_len_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(ID_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LEN = CNT_W'(ID_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_inc;

  assign cnt_inc = step_i && (cnt_q != CNT_SAT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (cnt_inc)    cnt_q <= cnt_q + 1'b1;
  end

  assign at_len_o = (cnt_q == CNT_LEN);

  p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/crc8_serial_unit.sv
module crc8_serial_unit
  import crc8_pkg::*;
#(
  parameter int ID_BITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             zero_o,
  output logic             id_ok_o
);
  logic             step_w;
  logic             at_len_w;
  logic [CRC_W-1:0] crc_w;

  // Clear beats a data bit arriving in the same cycle
  assign step_w = bit_vld_i && !clr_i;

  crc8_shift_reg u_sreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .step_i (step_w),
    .din_i  (bit_i),
    .crc_o  (crc_w)
  );

  crc8_bit_counter #(.ID_BITS(ID_BITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .step_i   (step_w),
    .at_len_o (at_len_w)
  );

  assign crc_o   = crc_w;
  assign zero_o  = (crc_w == '0);
  assign id_ok_o = zero_o && at_len_w;

  p_idok_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_ok_o |-> (crc_w == '0));
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && bit_vld_i) |=> !id_ok_o);
endmodule

// File: tb/crc8_serial_unit_tb.sv
module crc8_serial_unit_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic clr = 0, vld = 0, din = 0;
  logic [7:0] crc;
  logic zero, idok;
  int checks = 0, errors = 0;
  logic [7:0] model = 8'h00;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #5 clk = ~clk;

  crc8_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .bit_vld_i(vld), .bit_i(din),
    .crc_o(crc), .zero_o(zero), .id_ok_o(idok)
  );

  // Bench reference: explicit taps 7, 3 and 2 after a right shift
  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic b);
    logic f;
    logic [7:0] n;
    f = c[0] ^ b;
    n = {f, c[7:1]};
    n[3] = n[3] ^ f;
    n[2] = n[2] ^ f;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); vld = 1; din = b;
    @(negedge clk); vld = 0;
    model = ref_step(model, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    model = 8'h00;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [55:0] id;
    logic [7:0] cv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 crc", crc, 8'h00);
    chk("R1 zero", zero, 1);
    chk("R1 idok", idok, 0);

    // Known identity, R5 and R6
    do_clear();
    send_byte(8'h02); send_byte(8'h1C); send_byte(8'hB8); send_byte(8'h01);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    chk("R5 known", crc, 8'hA2);
    chk("R5 model", crc, model);
    chk("R8 nonzero", zero, 0);
    send_byte(8'hA2);
    chk("R6 residue", crc, 8'h00);
    chk("R6 idok", idok, 1);
    // R7: 65th zero bit keeps residue but drops id_ok
    send_bit(0);
    chk("R7 over crc", crc, 8'h00);
    chk("R8 zero over", zero, 1);
    chk("R7 over idok", idok, 0);

    // R3: idle cycles hold state
    do_clear(); send_byte(8'h5A);
    cv = crc;
    repeat (5) @(negedge clk);
    chk("R3 hold", crc, cv);

    // R4: clear with valid high drops the bit
    @(negedge clk); clr = 1; vld = 1; din = 1;
    @(negedge clk); clr = 0; vld = 0; model = 8'h00;
    chk("R4 clr priority", crc, 8'h00);
    send_bit(1);
    chk("R4 after clr", crc, 8'h8C);

    // R7: all-zero stream, 63 vs 64 bits
    do_clear();
    for (int i = 0; i < 63; i++) send_bit(0);
    chk("R7 63 zero", zero, 1);
    chk("R7 63 idok", idok, 0);
    send_bit(0);
    chk("R7 64 idok", idok, 1);

    // R2: exhaustive single-byte sweep
    for (int v = 0; v < 256; v++) begin
      do_clear();
      send_byte(8'(v));
      chk("R2 byte sweep", crc, model);
      chk("R8 sweep", zero, (model == 8'h00));
    end

    // R5/R6: pseudo-random identities
    for (int k = 0; k < 40; k++) begin
      do_clear();
      for (int j = 0; j < 56; j++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        id[j] = lfsr[0];
      end
      for (int j = 0; j < 56; j++) send_bit(id[j]);
      chk("R5 random", crc, model);
      cv = model;
      send_byte(cv);
      chk("R6 random crc", crc, 8'h00);
      chk("R6 random idok", idok, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule